// File: doc/BRIEF.md
# Sequential Byte-Sliced 16x16 Multiplier

This block forms the 32-bit product of two 16-bit operands with a single 8x8 unsigned multiplier that is reused over several clock cycles. A start strobe loads both operands and a mode flag. The block then walks through four byte-wise partial products in a fixed order. The low-by-low and high-by-high products are written straight into their halves of the result register. The two cross products are added in at byte 1 with carry into the upper bytes.

In two's-complement mode, up to two correction steps follow. The block takes no sign-extended inputs and uses no recoding. Instead, when an operand is negative, the other operand is subtracted from the upper 16 bits of the result. The correction for a negative second operand comes first, then the one for a negative first operand. A skipped correction costs no cycle, so a product takes 4, 5 or 6 cycles. Busy stays high while the block works. Done pulses once when the result is final, and the result then holds until the next accepted start.

Top module: `bytemul16_seq`

## Requirements
- R1: In unsigned mode (`signed_i` = 0 at start), the final product equals the unsigned 32-bit product of the two operands.
- R2: In signed mode (`signed_i` = 1 at start), the final product equals the two's-complement product of the operands, read as 32 bits. A set bit 15 marks an operand as negative.
- R3: `start_i` is accepted only while `busy_o` is low. Both operands and the mode flag are captured at that edge. A start during busy has no effect on the product or on the timing.
- R4: `busy_o` rises on the edge that accepts a start. It falls on the edge that completes the final step.
- R5: `done_o` is high for exactly one cycle. During that cycle `product_o` holds the final product and `busy_o` is low.
- R6: `done_o` rises on edge k+4+n, where k is the accepting edge and n is the number of corrections applied. n is 0 in unsigned mode. In signed mode, n is the count of operands with bit 15 set.
- R7: `product_o` holds its value while `busy_o` is low, until the next accepted start.
- R8: After a synchronous active-low reset, `busy_o`, `done_o` and `product_o` are all zero.
- R9: The first step writes the low-byte by low-byte product into result bits 15:0 on edge k+1. The second step writes the high-byte by high-byte product into bits 31:16 on edge k+2, without adding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy_o | output | 1 | High while a product is being formed |
| done_o | output | 1 | One-cycle pulse when the product is final |
| product_o | output | 32 | Result register |

## Verification
Taking the accepting edge as k, the low half of the result is due after edge k+1 and the high-by-high half after edge k+2. Done and the final product are due after edge k+4 in unsigned mode. In signed mode each negative operand adds one further edge. The bench drives and samples on falling edges and counts them from the accepting edge. At each of these points it compares against a latency and a product it works out from the operands and the mode. On the cycle after done, it checks that done has dropped and that the product has not moved.

// File: rtl/bmul_pkg.sv
// Shared step encoding for the byte-sliced multiplier.
// Assumes: one step is executed per clock cycle.
package bmul_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL,      // low x low into bits 15:0
        ST_HH,      // high x high into bits 31:16
        ST_LH,      // a low x b high, accumulate at byte 1
        ST_HL,      // a high x b low, accumulate at byte 1
        ST_SUB_A,   // b negative: upper half minus a
        ST_SUB_B    // a negative: upper half minus b
    } step_t;
endpackage

// File: rtl/bmul_core.sv
// Unsigned BW x BW multiplier, purely combinational.
// Assumes: the caller registers the result.
module bmul_core #(
    parameter int BW = 8
) (
    input  logic [BW-1:0]   x_i,
    input  logic [BW-1:0]   y_i,
    output logic [2*BW-1:0] p_o
);
    localparam int PW = 2 * BW;

    // zero-extended product of the two bytes
    assign p_o = PW'(x_i) * PW'(y_i);
endmodule

// File: rtl/bmul_opsel.sv
// Picks the operand bytes that feed the shared multiplier for the current step.
// Assumes: operands are exactly two bytes wide.
module bmul_opsel
    import bmul_pkg::*;
#(
    parameter int BW = 8
) (
    input  step_t           step_i,
    input  logic [2*BW-1:0] a_i,
    input  logic [2*BW-1:0] b_i,
    output logic [BW-1:0]   x_o,
    output logic [BW-1:0]   y_o
);
    logic [BW-1:0] a_byte [2];
    logic [BW-1:0] b_byte [2];

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_slice
            assign a_byte[gi] = a_i[gi*BW +: BW];
            assign b_byte[gi] = b_i[gi*BW +: BW];
        end
    endgenerate

    // byte routing per step
    always_comb begin
        x_o = '0;
        y_o = '0;
        case (step_i)
            ST_LL: begin x_o = a_byte[0]; y_o = b_byte[0]; end
            ST_HH: begin x_o = a_byte[1]; y_o = b_byte[1]; end
            ST_LH: begin x_o = a_byte[0]; y_o = b_byte[1]; end
            ST_HL: begin x_o = a_byte[1]; y_o = b_byte[0]; end
            default: ;
        endcase
    end
endmodule

// File: rtl/bmul_ctrl.sv
// Step sequencer: accepts start while idle, then runs the four partial-product
// steps and the corrections that apply, and pulses done on completion.
// Assumes: the mode and MSB inputs come from registers loaded at acceptance.
module bmul_ctrl
    import bmul_pkg::*;
#(
    parameter int LAT_W = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  sgn_i,
    input  logic  a_msb_i,
    input  logic  b_msb_i,
    output logic  accept_o,
    output step_t step_o,
    output logic  busy_o,
    output logic  done_o
);
    step_t st_q, st_d;
    logic  fix_a, fix_b;

    assign fix_a    = sgn_i & b_msb_i;   // subtract a when b negative
    assign fix_b    = sgn_i & a_msb_i;   // subtract b when a negative
    assign busy_o   = (st_q != ST_IDLE);
    assign accept_o = start_i & ~busy_o;
    assign step_o   = st_q;

    // next-step selection in the fixed order
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  st_d = accept_o ? ST_LL : ST_IDLE;
            ST_LL:    st_d = ST_HH;
            ST_HH:    st_d = ST_LH;
            ST_LH:    st_d = ST_HL;
            ST_HL:    st_d = fix_a ? ST_SUB_A : (fix_b ? ST_SUB_B : ST_IDLE);
            ST_SUB_A: st_d = fix_b ? ST_SUB_B : ST_IDLE;
            ST_SUB_B: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // step register and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_o <= (st_q != ST_IDLE) && (st_d == ST_IDLE);
        end
    end

    // cycle counter for the latency check
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        lat_q <= '0;
        else if (accept_o) lat_q <= '0;
        else if (busy_o)   lat_q <= lat_q + 1'b1;
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (32'(lat_q) == 32'd4 + 32'(fix_a) + 32'(fix_b)));
    // R4
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> busy_o);
endmodule

// File: rtl/bmul_acc.sv
// Result register: writes or accumulates each step's partial product at its
// byte offset and applies the sign-correction subtractions on the upper half.
// Assumes: steps arrive in the order LL, HH, LH, HL, then corrections.
module bmul_acc
    import bmul_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_t            step_i,
    input  logic [2*BW-1:0]  prod_i,
    input  logic [2*BW-1:0]  a_i,
    input  logic [2*BW-1:0]  b_i,
    output logic [4*BW-1:0]  res_o
);
    localparam int OPW = 2 * BW;
    localparam int RW  = 4 * BW;
    localparam int UPW = RW - BW;   // bits from byte 1 upward

    // per-step update of the result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o <= '0;
        end else begin
            case (step_i)
                ST_LL:        res_o[OPW-1:0]  <= prod_i;
                ST_HH:        res_o[RW-1:OPW] <= prod_i;
                ST_LH, ST_HL: res_o[RW-1:BW]  <= res_o[RW-1:BW] + UPW'(prod_i);
                ST_SUB_A:     res_o[RW-1:OPW] <= res_o[RW-1:OPW] - a_i;
                ST_SUB_B:     res_o[RW-1:OPW] <= res_o[RW-1:OPW] - b_i;
                default: ;
            endcase
        end
    end

    // R1
    cross_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == ST_LH || step_i == ST_HL) |=> $stable(res_o[BW-1:0]));
    // R2
    fix_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == ST_SUB_A || step_i == ST_SUB_B) |=> $stable(res_o[OPW-1:0]));
    // R9
    hh_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == ST_HH) |=> $stable(res_o[OPW-1:0]));
endmodule

// File: rtl/bytemul16_seq.sv
// Top: captures operands on an accepted start, steers bytes into one shared
// multiplier and collects the product over 4 to 6 cycles.
// Assumes: BYTE_W = 8 gives the 16x16 case; operands are two bytes wide.
module bytemul16_seq
    import bmul_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [2*BYTE_W-1:0]   opa_i,
    input  logic [2*BYTE_W-1:0]   opb_i,
    input  logic                  signed_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [4*BYTE_W-1:0]   product_o
);
    localparam int OPW = 2 * BYTE_W;
    localparam int RW  = 4 * BYTE_W;

    logic [OPW-1:0]    a_q, b_q;
    logic              sgn_q;
    logic              accept;
    step_t             step;
    logic [BYTE_W-1:0] mx, my;
    logic [OPW-1:0]    mp;

    // operand and mode capture on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            sgn_q <= 1'b0;
        end else if (accept) begin
            a_q   <= opa_i;
            b_q   <= opb_i;
            sgn_q <= signed_i;
        end
    end

    bmul_ctrl #(.LAT_W(3)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .sgn_i    (sgn_q),
        .a_msb_i  (a_q[OPW-1]),
        .b_msb_i  (b_q[OPW-1]),
        .accept_o (accept),
        .step_o   (step),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    bmul_opsel #(.BW(BYTE_W)) u_sel (
        .step_i (step),
        .a_i    (a_q),
        .b_i    (b_q),
        .x_o    (mx),
        .y_o    (my)
    );

    bmul_core #(.BW(BYTE_W)) u_core (
        .x_i (mx),
        .y_i (my),
        .p_o (mp)
    );

    bmul_acc #(.BW(BYTE_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .prod_i (mp),
        .a_i    (a_q),
        .b_i    (b_q),
        .res_o  (product_o)
    );

    // reference product for the completion check
    logic [RW-1:0] ref_a, ref_b, ref_p;
    assign ref_a = {{OPW{sgn_q & a_q[OPW-1]}}, a_q};
    assign ref_b = {{OPW{sgn_q & b_q[OPW-1]}}, b_q};
    assign ref_p = ref_a * ref_b;

    // R1 R2
    final_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == ref_p));
    // R3
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(a_q) && $stable(b_q) && $stable(sgn_q)));
    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));
endmodule

// File: tb/bytemul16_seq_test.sv
module bytemul16_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic        signed_i = 1'b0;
    logic        busy_o, done_o;
    logic [31:0] product_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    bytemul16_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .signed_i  (signed_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    // stimulus vectors {a, b, signed}; expected values are derived per requirement
    localparam int NV = 16;
    localparam logic [32:0] VEC [NV] = '{
        {16'h0000, 16'h0000, 1'b0}, {16'hFFFF, 16'hFFFF, 1'b0},
        {16'h8000, 16'h8000, 1'b0}, {16'h7FFF, 16'h7FFF, 1'b0},
        {16'hFFFF, 16'h0000, 1'b0}, {16'h8000, 16'h7FFF, 1'b0},
        {16'h0000, 16'h0000, 1'b1}, {16'hFFFF, 16'hFFFF, 1'b1},
        {16'h8000, 16'h8000, 1'b1}, {16'h7FFF, 16'h7FFF, 1'b1},
        {16'hFFFF, 16'h7FFF, 1'b1}, {16'h7FFF, 16'h8000, 1'b1},
        {16'h8000, 16'h7FFF, 1'b1}, {16'hFFFF, 16'h0001, 1'b1},
        {16'h1234, 16'hABCD, 1'b0}, {16'h00FF, 16'hFF00, 1'b1}
    };

    function automatic logic [31:0] expect_prod(logic [15:0] a, logic [15:0] b, logic s);
        logic [31:0] ea, eb;
        ea = {{16{s & a[15]}}, a};
        eb = {{16{s & b[15]}}, b};
        return ea * eb;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one product; optional start pulses while busy (R3)
    task automatic run(input logic [15:0] a, input logic [15:0] b, input logic s, input logic poke);
        int n;
        int lat;
        logic [31:0] exp_p;
        exp_p = expect_prod(a, b, s);
        n = 4 + ((s && b[15]) ? 1 : 0) + ((s && a[15]) ? 1 : 0);
        @(negedge clk);
        opa_i = a; opb_i = b; signed_i = s; start_i = 1'b1;
        @(negedge clk);                               // after accepting edge k
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R4 busy after start", 32'(busy_o), 32'd1);
        if (poke) begin
            start_i = 1'b1; opa_i = ~a; opb_i = ~b; signed_i = ~s;
        end
        @(negedge clk);                               // after k+1
        chk(product_o[15:0] == 16'(a[7:0] * b[7:0]), "R9 low step",
            32'(product_o[15:0]), 32'(a[7:0] * b[7:0]));
        @(negedge clk);                               // after k+2
        start_i = 1'b0;
        chk(product_o[31:16] == 16'(a[15:8] * b[15:8]), "R9 high step",
            32'(product_o[31:16]), 32'(a[15:8] * b[15:8]));
        lat = 2;
        while (!done_o && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == n, "R6 latency", 32'(lat), 32'(n));
        chk(product_o == exp_p, s ? "R2 signed product" : "R1 unsigned product", product_o, exp_p);
        chk(busy_o == 1'b0, "R5 busy low at done", 32'(busy_o), 32'd0);
        @(negedge clk);
        chk(done_o == 1'b0, "R5 single done pulse", 32'(done_o), 32'd0);
        chk(product_o == exp_p, "R7 result held", product_o, exp_p);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(busy_o == 1'b0, "R8 busy reset", 32'(busy_o), 32'd0);
        chk(done_o == 1'b0, "R8 done reset", 32'(done_o), 32'd0);
        chk(product_o == 32'd0, "R8 product reset", product_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][32:17], VEC[i][16:1], VEC[i][0], 1'b0);
        end

        // R3: start held during busy must not disturb the running product
        run(16'h8001, 16'hC003, 1'b1, 1'b1);
        run(16'hFEDC, 16'h0123, 1'b0, 1'b1);

        // R7: idle inputs change without start; product stays
        @(negedge clk);
        opa_i = 16'h5555; opb_i = 16'hAAAA; signed_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(product_o == expect_prod(16'hFEDC, 16'h0123, 1'b0), "R7 idle hold",
            product_o, expect_prod(16'hFEDC, 16'h0123, 1'b0));

        for (int i = 0; i < 40; i++) begin
            run(16'($urandom), 16'($urandom), 1'($urandom), 1'b0);
        end

        // R8 reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(product_o == 32'd0, "R8 product cleared", product_o, 32'd0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule